// File: doc/BRIEF.md
# Watermark-Gated Interrupt Controller

This block collects interrupt causes for a packet network interface and drives a single CPU interrupt line. The receive and transmit paths send one-cycle event pulses, one bit per cause, into an 8-bit status register. An 8-bit mask register selects which pending causes may interrupt. Software reads the status register to learn what happened, which also clears it, or clears chosen bits by writing ones to them.

Two causes are filtered before they reach the status register. The receive high-mark cause counts only if the receive FIFO has run empty since it was last accepted. The transmit low-mark cause counts only if the transmit FIFO has been full since it was last accepted. This stops a FIFO that hovers around its watermark from raising a stream of interrupts. FIFO-state causes raise the line on the next clock. Every other cause waits out a programmable coalescing delay first, so that several completions can share one interrupt.

Top module: `intc_wm_ctrl`

## Requirements
- R1: Status bit positions are: 0 receive packet, 1 receive DMA done, 2 receive FIFO empty, 3 receive above high mark, 4 transmit packet sent, 5 transmit DMA done, 6 transmit FIFO full, 7 transmit below low mark. A high bit on `evt_post` sets that status bit on the next clock, and set bits stay set until cleared.
- R2: A `rx_fifo_empty` high in any cycle sets a receive gate flag. A post of bit 3 enters status only if the flag is already set, and accepting it clears the flag. Without the flag the post is discarded. If `rx_fifo_empty` is high in the same cycle, the flag stays set.
- R3: A `tx_fifo_full` high sets a transmit gate flag, and bit 7 posts are gated by it exactly as in R2.
- R4: `stat_rdata` always shows the current status. A cycle with `stat_rd` high clears every status bit on the following clock, but posts in that same cycle are kept.
- R5: A cycle with `stat_wr` high clears exactly the status bits that are 1 in `stat_wdata`. `stat_rd` takes priority when both are high.
- R6: Reset is synchronous and active high. After reset, status is 0, the mask is 0x8A (bits 1, 3 and 7), both gate flags are clear and `intr_o` is low.
- R7: When `intr_en` is high and a set status bit within 0xCC (bits 2, 3, 6, 7) is also enabled in the mask, `intr_o` is high on the next clock.
- R8: When only causes outside 0xCC are pending and enabled, `intr_o` rises DELAY+1 clocks after the pending set first becomes non-empty. An immediate cause arriving during the countdown raises the line on the next clock.
- R9: While `intr_en` is low, `intr_o` is low on the next clock, and status still accumulates.
- R10: `intr_o` is low on the clock after status and mask share no set bit.
- R11: A `mask_wr` pulse loads `mask_wdata` into the mask on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_post | input | 8 | One-cycle event pulses, one bit per cause |
| rx_fifo_empty | input | 1 | Receive FIFO has run empty |
| tx_fifo_full | input | 1 | Transmit FIFO has become full |
| stat_rd | input | 1 | Status read strobe (clear after capture) |
| stat_wr | input | 1 | Status write strobe (write one to clear) |
| stat_wdata | input | 8 | Status write data |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| intr_en | input | 1 | Global interrupt enable |
| intr_o | output | 1 | CPU interrupt line |
| stat_rdata | output | 8 | Current status value |
| mask_rdata | output | 8 | Current mask value |

## Verification
The assertions check on every cycle the relations that hold one clock apart at the ports. These cover the reset values, the disable by `intr_en`, the immediate raise for FIFO-state causes, the drop once nothing pending is enabled, the clear on read, write-one-to-clear, and mask loading. The watermark gating and the exact length of the coalescing wait depend on history, which a one-step property cannot express. Only the bench shows them. It runs directed sequences for each of these and a cycle-accurate reference model that is compared against every output under random traffic.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NCAUSE = 8;
    typedef logic [NCAUSE-1:0] cause_t;

    localparam int B_RX_PKT   = 0;
    localparam int B_RX_DMA   = 1;
    localparam int B_RX_EMPTY = 2;
    localparam int B_RX_HIGH  = 3;
    localparam int B_TX_PKT   = 4;
    localparam int B_TX_DMA   = 5;
    localparam int B_TX_FULL  = 6;
    localparam int B_TX_LOW   = 7;

    localparam cause_t IMM_MASK = 8'hCC;
    localparam cause_t RST_MASK = 8'h8A;

    // watermark gates: 0 = receive high mark, 1 = transmit low mark
    localparam int NGATE = 2;

    function automatic int gate_bit(int g);
        return (g == 0) ? B_RX_HIGH : B_TX_LOW;
    endfunction

    typedef struct packed {
        cause_t stat;
        cause_t mask;
    } regs_t;

    function automatic cause_t clear_set(logic rd, logic wr, cause_t wd);
        if (rd)
            return '1;
        else if (wr)
            return wd;
        return '0;
    endfunction
endpackage

// File: rtl/intc_wm_gate.sv
module intc_wm_gate (
    input  logic clk,
    input  logic rst,
    input  logic extreme,
    input  logic cause_in,
    output logic cause_out
);
    logic armed_q;

    assign cause_out = cause_in & armed_q;

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (extreme)
            armed_q <= 1'b1;
        else if (cause_out)
            armed_q <= 1'b0;
    end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t post,
    input  logic   rd,
    input  logic   wr,
    input  cause_t wdata,
    input  logic   mask_wr,
    input  cause_t mask_wdata,
    output regs_t  q
);
    regs_t  d;
    cause_t clr;

    always_comb begin
        clr    = clear_set(rd, wr, wdata);
        d.stat = (q.stat & ~clr) | post;
        d.mask = mask_wr ? mask_wdata : q.mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.stat <= '0;
            q.mask <= RST_MASK;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/intc_coalesce.sv
module intc_coalesce
    import intc_pkg::*;
#(
    parameter int DELAY = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  cause_t pend,
    output logic   irq
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
    localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic          fire;
    logic          irq_d;

    always_comb begin
        fire  = armed_q && (cnt_q == '0);
        irq_d = en && (pend != '0) &&
                (irq || ((pend & IMM_MASK) != '0) || fire);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            irq <= irq_d;
            if (!en || pend == '0 || irq_d) begin
                armed_q <= 1'b0;
            end else if (!armed_q) begin
                armed_q <= 1'b1;
                cnt_q   <= LOAD;
            end else begin
                cnt_q   <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/intc_wm_ctrl.sv
module intc_wm_ctrl
    import intc_pkg::*;
#(
    parameter int DELAY = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] evt_post,
    input  logic       rx_fifo_empty,
    input  logic       tx_fifo_full,
    input  logic       stat_rd,
    input  logic       stat_wr,
    input  logic [7:0] stat_wdata,
    input  logic       mask_wr,
    input  logic [7:0] mask_wdata,
    input  logic       intr_en,
    output logic       intr_o,
    output logic [7:0] stat_rdata,
    output logic [7:0] mask_rdata
);
    logic [NGATE-1:0] extremes;
    logic [NGATE-1:0] gate_out;
    cause_t           post_g;
    regs_t            regs_q;

    assign extremes = {tx_fifo_full, rx_fifo_empty};

    for (genvar g = 0; g < NGATE; g++) begin : g_gate
        localparam int BIT = gate_bit(g);
        intc_wm_gate u_gate (
            .clk      (clk),
            .rst      (rst),
            .extreme  (extremes[g]),
            .cause_in (evt_post[BIT]),
            .cause_out(gate_out[g])
        );
    end

    always_comb begin
        post_g = evt_post;
        for (int g = 0; g < NGATE; g++)
            post_g[gate_bit(g)] = gate_out[g];
    end

    intc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .post      (post_g),
        .rd        (stat_rd),
        .wr        (stat_wr),
        .wdata     (stat_wdata),
        .mask_wr   (mask_wr),
        .mask_wdata(mask_wdata),
        .q         (regs_q)
    );

    intc_coalesce #(.DELAY(DELAY)) u_coal (
        .clk (clk),
        .rst (rst),
        .en  (intr_en),
        .pend(regs_q.stat & regs_q.mask),
        .irq (intr_o)
    );

    assign stat_rdata = regs_q.stat;
    assign mask_rdata = regs_q.mask;
endmodule

// File: rtl/intc_wm_ctrl_chk.sv
module intc_wm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] evt_post,
    input logic       rx_fifo_empty,
    input logic       tx_fifo_full,
    input logic       stat_rd,
    input logic       stat_wr,
    input logic [7:0] stat_wdata,
    input logic       mask_wr,
    input logic [7:0] mask_wdata,
    input logic       intr_en,
    input logic       intr_o,
    input logic [7:0] stat_rdata,
    input logic [7:0] mask_rdata
);
    assert_reset_state_R6: assert property (@(posedge clk)
        rst |=> (stat_rdata == 8'h00 && mask_rdata == 8'h8A && !intr_o));

    assert_en_low_R9: assert property (@(posedge clk) disable iff (rst)
        !intr_en |=> !intr_o);

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        ((stat_rdata & mask_rdata) == 8'h00) |=> !intr_o);

    assert_immediate_R7: assert property (@(posedge clk) disable iff (rst)
        (intr_en && (stat_rdata & mask_rdata & 8'hCC) != 8'h00) |=> intr_o);

    assert_read_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && evt_post == 8'h00) |=> stat_rdata == 8'h00);

    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !stat_rd && evt_post == 8'h00)
        |=> (stat_rdata & $past(stat_wdata)) == 8'h00);

    assert_mask_load_R11: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> mask_rdata == $past(mask_wdata));
endmodule

bind intc_wm_ctrl intc_wm_ctrl_chk u_chk (.*);

// File: tb/intc_wm_ctrl_tb.sv
module intc_wm_ctrl_tb;
    localparam int DLY = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt_post = '0;
    logic       rx_fifo_empty = 1'b0;
    logic       tx_fifo_full = 1'b0;
    logic       stat_rd = 1'b0;
    logic       stat_wr = 1'b0;
    logic [7:0] stat_wdata = '0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       intr_en = 1'b0;
    logic       intr_o;
    logic [7:0] stat_rdata;
    logic [7:0] mask_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    intc_wm_ctrl #(.DELAY(DLY)) u_dut (.*);

    // reference model, built from the requirements
    logic [7:0] m_stat = '0, m_mask = 8'h8A;
    logic       m_rxf = 1'b0, m_txf = 1'b0, m_intr = 1'b0, m_arm = 1'b0;
    int         m_cnt = 0;

    function automatic logic [7:0] clr_of(logic rd, logic wr, logic [7:0] wd);
        return rd ? 8'hFF : (wr ? wd : 8'h00);
    endfunction

    function automatic logic next_line(logic en, logic [7:0] pend, logic cur, logic fire);
        return en && pend != 0 && (cur || (pend & 8'hCC) != 0 || fire);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stat = '0; m_mask = 8'h8A; m_rxf = 0; m_txf = 0;
            m_intr = 0; m_arm = 0; m_cnt = 0;
        end else begin
            logic [7:0] p, pend;
            logic acc_h, acc_l, fire, nl;
            p = evt_post;
            acc_h = p[3] & m_rxf;   // R2
            acc_l = p[7] & m_txf;   // R3
            p[3] = acc_h;
            p[7] = acc_l;
            m_rxf = rx_fifo_empty ? 1'b1 : (acc_h ? 1'b0 : m_rxf);
            m_txf = tx_fifo_full  ? 1'b1 : (acc_l ? 1'b0 : m_txf);
            pend = m_stat & m_mask;
            fire = m_arm && m_cnt == 0;
            nl = next_line(intr_en, pend, m_intr, fire);
            if (!intr_en || pend == 0 || nl) m_arm = 0;
            else if (!m_arm) begin m_arm = 1; m_cnt = DLY - 1; end
            else m_cnt = m_cnt - 1;
            m_intr = nl;
            m_stat = (m_stat & ~clr_of(stat_rd, stat_wr, stat_wdata)) | p;
            if (mask_wr) m_mask = mask_wdata;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FIL%s %s actual=%0h expected=%0h at %0t", "", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            chk("R1 status", {24'd0, stat_rdata}, {24'd0, m_stat});
            chk("R11 mask", {24'd0, mask_rdata}, {24'd0, m_mask});
            chk("R8 line", {31'd0, intr_o}, {31'd0, m_intr});
        end
    end

    task automatic idle();
        evt_post = '0; rx_fifo_empty = 0; tx_fifo_full = 0;
        stat_rd = 0; stat_wr = 0; mask_wr = 0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        // R6: reset values
        chk("R6 status", {24'd0, stat_rdata}, 32'h00);
        chk("R6 mask", {24'd0, mask_rdata}, 32'h8A);
        chk("R6 line", {31'd0, intr_o}, 32'd0);
        cmp_on = 1;
        intr_en = 1;

        // R2: high mark without prior empty is dropped
        evt_post = 8'h08; step(); idle(); step();
        chk("R2 dropped", {24'd0, stat_rdata}, 32'h00);
        rx_fifo_empty = 1; step(); idle();
        evt_post = 8'h08; step(); idle();
        chk("R2 accepted", {24'd0, stat_rdata}, 32'h08);
        step();
        chk("R7 immediate", {31'd0, intr_o}, 32'd1);
        stat_rd = 1; step(); idle();
        chk("R4 read clears", {24'd0, stat_rdata}, 32'h00);
        step();
        chk("R10 line drop", {31'd0, intr_o}, 32'd0);
        evt_post = 8'h08; step(); idle();
        chk("R2 flag consumed", {24'd0, stat_rdata}, 32'h00);

        // R3: low mark gated by full
        evt_post = 8'h80; step(); idle();
        chk("R3 dropped", {24'd0, stat_rdata}, 32'h00);
        tx_fifo_full = 1; evt_post = 8'h80; step(); idle();
        chk("R3 not yet armed", {24'd0, stat_rdata}, 32'h00);
        evt_post = 8'h80; step(); idle();
        chk("R3 accepted", {24'd0, stat_rdata}, 32'h80);
        stat_wr = 1; stat_wdata = 8'h80; step(); idle();
        chk("R5 w1c", {24'd0, stat_rdata}, 32'h00);
        step();

        // R8: delayed cause, line rises DLY+1 clocks after status shows it
        evt_post = 8'h02; step(); idle();
        chk("R8 status set", {24'd0, stat_rdata}, 32'h02);
        for (int i = 0; i < DLY; i++) step();
        chk("R8 still waiting", {31'd0, intr_o}, 32'd0);
        step();
        chk("R8 fires", {31'd0, intr_o}, 32'd1);
        stat_rd = 1; step(); idle(); step();

        // R8: immediate cause cuts the countdown short
        evt_post = 8'h02; step(); idle(); step(); step();
        rx_fifo_empty = 1; step(); idle();
        evt_post = 8'h08; step(); idle();
        chk("R8 early status", {24'd0, stat_rdata}, 32'h0A);
        step();
        chk("R8 early fire", {31'd0, intr_o}, 32'd1);

        // R9: disabled line, status accumulates
        intr_en = 0; evt_post = 8'h20; step(); idle(); step();
        chk("R9 line low", {31'd0, intr_o}, 32'd0);
        chk("R9 accumulates", {24'd0, stat_rdata}, 32'h2A);
        intr_en = 1;

        // R4: post during read survives; R5 partial clear
        stat_rd = 1; evt_post = 8'h11; step(); idle();
        chk("R4 same-cycle post kept", {24'd0, stat_rdata}, 32'h11);
        stat_wr = 1; stat_wdata = 8'h01; step(); idle();
        chk("R5 partial clear", {24'd0, stat_rdata}, 32'h10);

        // R11 mask write; R1 posting with full mask
        mask_wr = 1; mask_wdata = 8'h10; step(); idle();
        chk("R11 mask load", {24'd0, mask_rdata}, 32'h10);
        stat_rd = 1; step(); idle();
        evt_post = 8'h77; step(); idle();
        chk("R1 bits or in", {24'd0, stat_rdata}, 32'h77);
        stat_rd = 1; step(); idle();

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            evt_post      = 8'($urandom) & 8'($urandom) & 8'($urandom);
            rx_fifo_empty = ($urandom % 8) == 0;
            tx_fifo_full  = ($urandom % 8) == 0;
            stat_rd       = ($urandom % 10) == 0;
            stat_wr       = ($urandom % 12) == 0;
            stat_wdata    = 8'($urandom);
            mask_wr       = ($urandom % 25) == 0;
            mask_wdata    = 8'($urandom);
            intr_en       = ($urandom % 16) != 0;
            step();
        end
        idle();
        step();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule